// File: doc/BRIEF.md
# System-Management Watchdog Timer

This block is a watchdog for a system-management register block. Software programs a timer value, loads a down-counter from it and lets the counter run. The counter steps down once for each one-cycle slow-tick strobe; one tick stands for 0.6 s. When the count runs out, a timeout flag is raised and the counter reloads itself and keeps going. If software does not intervene before the following expiry, the block records a second timeout and a boot flag. Unless the no-reboot input is held high, it also issues a single-cycle action request that a system controller outside the block turns into a reset or another response.

Software reaches the block through a byte-enabled, word-wide register port. Writes take effect at the clock edge where `wr_en` is sampled high. Read data is combinational from `addr` and has no side effects. The port also carries a sticky lock bit, write-one-to-clear status and a pair of mailbox bytes whose writes raise status. A four-state expiry machine follows how far the two-stage timeout has advanced. EXP_IDLE means no expiry yet. EXP_FIRST means one expiry has happened. EXP_FIRE is the single cycle that drives the action request. EXP_DONE means the second stage has been reached. The transitions are:

- idle-to-first on an expiry.
- first-to-fire on an expiry while no-reboot is low.
- first-to-done on an expiry while no-reboot is high.
- fire-to-done unconditionally, one cycle later.
- any-to-idle on a restart, which is a reload write or the halt bit being set.

Register words, selected by `addr[4:2]`:

- 0x00: bits 15:0 give the remaining count. Writing byte 0 or byte 1 reloads the counter. Bits 23:16 hold the data-in byte and bits 31:24 the data-out byte.
- 0x04: bits 15:0 are status one. Bit 0 is interrupt, bit 1 is SMI and bit 3 is timeout. Bits 31:16 are status two. Bit 17 is second-timeout and bit 18 is boot.
- 0x08: bits 15:0 are control one. Bit 11 is halt and bit 12 is lock. Bits 31:16 are control two.
- 0x0C: bits 9:0 hold the timer value and bits 23:16 hold the software-IRQ byte.
- 0x10: byte 0 is message one, byte 1 is message two and byte 2 is the watchdog-count byte.
- All other words read zero.

Top module: `sysmgmt_watchdog`

## Requirements
- R1: After reset the words read as follows: 0x00 reads 0, 0x04 reads 0, 0x08 reads 0x00080000 (control two = 0x0008), 0x0C reads 0x00030004 (software-IRQ byte 0x03, timer value 4) and 0x10 reads 0.
- R2: A write to word 0x00 with byte enable 0 or 1 set loads the counter from the timer value, whatever data is written. Word 0x00 bits 15:0 then read the loaded value.
- R3: While not halted, each tick lowers the count by one. The tick that would take the count from 1 (or a tick at count 0) is an expiry: it sets status bit 3 and reloads the counter from the timer value.
- R4: While halt (word 0x08 bit 11) is 1, ticks leave the count unchanged. Clearing halt resumes counting.
- R5: The timer value keeps only bits 9:0 of a write. After 0xFFFF is written, a load gives 1023; 1022 ticks later the count reads 1 with bit 3 clear, and the next tick sets bit 3.
- R6: A second expiry with no restart since the first sets status bits 17 and 18. If no_reboot is low, action_req is high for exactly one cycle.
- R7: If no_reboot is high at the second expiry, status bits 17 and 18 are still set, but no action request is issued.
- R8: After the second stage is reached, later expiries issue no further request until a reload or halt restarts the two-stage sequence.
- R9: A write to byte 2 (data-in) or byte 3 (data-out) of word 0x00 stores the byte and sets status bits 0 and 1. It does not reload the counter.
- R10: Status bits are write-one-to-clear per enabled byte. Writing ones over word 0x04 returns it to zero, and a set event in the same cycle wins over the clear.
- R11: Once lock (word 0x08 bit 12) is written to 1, later writes cannot clear it, while halt stays writable.
- R12: Writes change only the bytes whose enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow-tick strobe (0.6 s period) |
| no_reboot | input | 1 | High suppresses the action request |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Byte address; bits 4:2 select the word |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte enables for the write |
| rdata | output | 32 | Read data for `addr` |
| action_req | output | 1 | Single-cycle action/reset request |

## Verification
The bench builds the block with its defaults: a 10-bit timer field and a 5-bit address. At these widths the whole count range, 1023 ticks, fits within a few thousand cycles. This brings the mask truncation and the count-reads-one boundary just before the last tick within direct reach. Ticks arrive every other cycle, so reload, halt and status writes can be placed between them. Both settings of no-reboot are run across the first-to-second expiry path, and the single issue of the request is observed across repeated expiries and a restart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        EXP_IDLE  = 2'd0,
        EXP_FIRST = 2'd1,
        EXP_FIRE  = 2'd2,
        EXP_DONE  = 2'd3
    } exp_state_t;

    // Word indices (addr[4:2])
    localparam int WORD_CNT = 0;
    localparam int WORD_STS = 1;
    localparam int WORD_CTL = 2;
    localparam int WORD_TMR = 3;
    localparam int WORD_MSG = 4;

    // Bit positions inside the 32-bit words
    localparam int S1_INT     = 0;
    localparam int S1_SMI     = 1;
    localparam int S1_TIMEOUT = 3;
    localparam int S2_SECOND  = 17;
    localparam int S2_BOOT    = 18;
    localparam int C1_HALT    = 11;
    localparam int C1_LOCK    = 12;

    localparam logic [15:0] TMR_RESET   = 16'h0004;
    localparam logic [15:0] CTL2_RESET  = 16'h0008;
    localparam logic [7:0]  SWIRQ_RESET = 8'h03;
    localparam int          MSG_BYTES   = 3;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             load,
    input  logic [CNT_W-1:0] tmr_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        expire = tick && !halt && !load && (count <= ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= tmr_val;
        end else if (tick && !halt) begin
            if (expire) begin
                count <= tmr_val;
            end else begin
                count <= count - ONE;
            end
        end
    end

endmodule

// File: rtl/wdt_expiry_fsm.sv
module wdt_expiry_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic restart,
    input  logic no_reboot,
    output logic second_hit,
    output logic action_req
);

    exp_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EXP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = EXP_IDLE;
        end else begin
            unique case (state_q)
                EXP_IDLE:  if (expire) state_d = EXP_FIRST;
                EXP_FIRST: if (expire) state_d = no_reboot ? EXP_DONE : EXP_FIRE;
                EXP_FIRE:  state_d = EXP_DONE;
                EXP_DONE:  state_d = EXP_DONE;
                default:   state_d = EXP_IDLE;
            endcase
        end
    end

    always_comb begin
        action_req = (state_q == EXP_FIRE);
        second_hit = expire && (state_q != EXP_IDLE);
    end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    input  logic              second_hit,
    output logic [31:0]       rdata,
    output logic              halt,
    output logic              lock,
    output logic              load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              sts_timeout,
    output logic              sts_second
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic hit_cnt, hit_sts, hit_ctl, hit_tmr, hit_msg, mbox_wr;
    logic int_q, smi_q, to_q, sec_q, boot_q;
    logic halt_q, lock_q;
    logic [15:0] ctl2_q;
    logic [CNT_W-1:0] tmr_q;
    logic [7:0] swirq_q, din_q, dout_q;
    logic [7:0] msg_q [MSG_BYTES];
    logic [15:0] tmr_merge;

    always_comb begin
        word    = addr[ADDR_W-1:2];
        hit_cnt = wr_en && (word == WORD_W'(WORD_CNT));
        hit_sts = wr_en && (word == WORD_W'(WORD_STS));
        hit_ctl = wr_en && (word == WORD_W'(WORD_CTL));
        hit_tmr = wr_en && (word == WORD_W'(WORD_TMR));
        hit_msg = wr_en && (word == WORD_W'(WORD_MSG));
        load    = hit_cnt && (be[0] || be[1]);
        mbox_wr = hit_cnt && (be[2] || be[3]);
        tmr_merge[7:0]  = be[0] ? wdata[7:0]  : 8'(16'(tmr_q));
        tmr_merge[15:8] = be[1] ? wdata[15:8] : 16'(tmr_q) >> 8;
    end

    // Status: set wins over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= 1'b0;
            smi_q  <= 1'b0;
            to_q   <= 1'b0;
            sec_q  <= 1'b0;
            boot_q <= 1'b0;
        end else begin
            int_q  <= mbox_wr    || (int_q  && !(hit_sts && be[0] && wdata[S1_INT]));
            smi_q  <= mbox_wr    || (smi_q  && !(hit_sts && be[0] && wdata[S1_SMI]));
            to_q   <= expire     || (to_q   && !(hit_sts && be[0] && wdata[S1_TIMEOUT]));
            sec_q  <= second_hit || (sec_q  && !(hit_sts && be[2] && wdata[S2_SECOND]));
            boot_q <= second_hit || (boot_q && !(hit_sts && be[2] && wdata[S2_BOOT]));
        end
    end

    // Control, timer value, software IRQ, mailbox bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q  <= 1'b0;
            lock_q  <= 1'b0;
            ctl2_q  <= CTL2_RESET;
            tmr_q   <= CNT_W'(TMR_RESET);
            swirq_q <= SWIRQ_RESET;
            din_q   <= 8'h00;
            dout_q  <= 8'h00;
        end else begin
            if (hit_ctl && be[1]) begin
                halt_q <= wdata[C1_HALT];
                lock_q <= lock_q || wdata[C1_LOCK];
            end
            if (hit_ctl && be[2]) ctl2_q[7:0]  <= wdata[23:16];
            if (hit_ctl && be[3]) ctl2_q[15:8] <= wdata[31:24];
            if (hit_tmr && (be[0] || be[1])) tmr_q <= tmr_merge[CNT_W-1:0];
            if (hit_tmr && be[2]) swirq_q <= wdata[23:16];
            if (hit_cnt && be[2]) din_q   <= wdata[23:16];
            if (hit_cnt && be[3]) dout_q  <= wdata[31:24];
        end
    end

    for (genvar b = 0; b < MSG_BYTES; b++) begin : g_msg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                msg_q[b] <= 8'h00;
            end else if (hit_msg && be[b]) begin
                msg_q[b] <= wdata[8*b +: 8];
            end
        end
    end

    always_comb begin
        rdata = 32'h0;
        case (word)
            WORD_W'(WORD_CNT): rdata = {dout_q, din_q, 16'(count)};
            WORD_W'(WORD_STS): begin
                rdata[S1_INT]     = int_q;
                rdata[S1_SMI]     = smi_q;
                rdata[S1_TIMEOUT] = to_q;
                rdata[S2_SECOND]  = sec_q;
                rdata[S2_BOOT]    = boot_q;
            end
            WORD_W'(WORD_CTL): begin
                rdata[31:16]   = ctl2_q;
                rdata[C1_HALT] = halt_q;
                rdata[C1_LOCK] = lock_q;
            end
            WORD_W'(WORD_TMR): rdata = {8'h00, swirq_q, 16'(tmr_q)};
            WORD_W'(WORD_MSG): rdata = {8'h00, msg_q[2], msg_q[1], msg_q[0]};
            default:           rdata = 32'h0;
        endcase
    end

    always_comb begin
        halt        = halt_q;
        lock        = lock_q;
        tmr_val     = tmr_q;
        sts_timeout = to_q;
        sts_second  = sec_q;
    end

endmodule

// File: rtl/sysmgmt_watchdog.sv
module sysmgmt_watchdog #(
    parameter int CNT_W  = 10,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              no_reboot,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        be,
    output logic [31:0]       rdata,
    output logic              action_req
);

    logic             halt, lock, load, expire, second_hit;
    logic             sts_timeout, sts_second, restart;
    logic [CNT_W-1:0] count, tmr_val;

    always_comb restart = halt || load;

    wdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .be(be), .count(count), .expire(expire),
        .second_hit(second_hit), .rdata(rdata), .halt(halt),
        .lock(lock), .load(load), .tmr_val(tmr_val),
        .sts_timeout(sts_timeout), .sts_second(sts_second)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt),
        .load(load), .tmr_val(tmr_val), .count(count), .expire(expire)
    );

    wdt_expiry_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .expire(expire), .restart(restart),
        .no_reboot(no_reboot), .second_hit(second_hit),
        .action_req(action_req)
    );

endmodule

// File: rtl/sysmgmt_watchdog_chk.sv
module sysmgmt_watchdog_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             action_req,
    input logic             no_reboot,
    input logic             halt,
    input logic             lock,
    input logic             load,
    input logic             expire,
    input logic             sts_timeout,
    input logic             sts_second,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] tmr_val
);

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(tmr_val)));

    // R3
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sts_timeout);

    // R4
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(count));

    // R6
    action_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        action_req |=> !action_req);

    // R6
    action_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        action_req |-> sts_second);

    // R7
    action_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        action_req |-> !$past(no_reboot));

    // R11
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

endmodule

bind sysmgmt_watchdog sysmgmt_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .action_req(action_req), .no_reboot(no_reboot),
    .halt(halt), .lock(lock), .load(load), .expire(expire),
    .sts_timeout(sts_timeout), .sts_second(sts_second),
    .count(count), .tmr_val(tmr_val)
);

// File: tb/sysmgmt_watchdog_tb.sv
module sysmgmt_watchdog_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        no_reboot = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic        action_req;

    int nchk = 0;
    int nerr = 0;
    int act_cnt = 0;

    typedef struct {
        logic [4:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q [$];

    always #2.5 clk = ~clk;

    sysmgmt_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .no_reboot(no_reboot),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .be(be),
        .rdata(rdata), .action_req(action_req)
    );

    // Monitor: pops expected reads, counts action pulses
    always @(negedge clk) begin
        item_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            nchk++;
            if (rdata !== it.exp) begin
                nerr++;
                $display("FAIL %s: addr %h got %h expected %h", it.tag, it.a, rdata, it.exp);
            end
        end
        if (action_req === 1'b1) act_cnt++;
    end

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        addr = a;
        it.a = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] b);
        @(posedge clk); #1;
        addr = a; wdata = d; be = b; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; be = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick = 1'b1;
            @(posedge clk); #1; tick = 1'b0;
        end
    endtask

    task automatic chk_act(input int e, input string tag);
        @(negedge clk); #1;
        nchk++;
        if (act_cnt != e) begin
            nerr++;
            $display("FAIL %s: action pulses got %0d expected %0d", tag, act_cnt, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 defaults
        expect_rd(5'h00, 32'h0000_0000, "R1 count word");
        expect_rd(5'h04, 32'h0000_0000, "R1 status");
        expect_rd(5'h08, 32'h0008_0000, "R1 control");
        expect_rd(5'h0C, 32'h0003_0004, "R1 timer word");
        expect_rd(5'h10, 32'h0000_0000, "R1 message word");

        // R2 load, R3 countdown, R4 halt
        wr(5'h08, 32'h0000_0800, 4'b0010);
        wr(5'h0C, 32'h0000_0008, 4'b0011);
        wr(5'h00, 32'h0000_0000, 4'b0011);
        expect_rd(5'h00, 32'h0000_0008, "R2 loaded count");
        wr(5'h08, 32'h0000_0000, 4'b0010);
        ticks(3);
        expect_rd(5'h00, 32'h0000_0005, "R3 count after 3 ticks");
        wr(5'h08, 32'h0000_0800, 4'b0010);
        ticks(2);
        expect_rd(5'h00, 32'h0000_0005, "R4 frozen while halted");
        wr(5'h08, 32'h0000_0000, 4'b0010);
        ticks(4);
        expect_rd(5'h00, 32'h0000_0001, "R4 resumed count");
        expect_rd(5'h04, 32'h0000_0000, "R3 no timeout at 1");
        ticks(1);
        expect_rd(5'h04, 32'h0000_0008, "R3 timeout set");
        expect_rd(5'h00, 32'h0000_0008, "R3 reloaded after expiry");
        chk_act(0, "R6 no request on first expiry");

        // R10 clear, R6 second expiry
        wr(5'h04, 32'h0000_0008, 4'b0001);
        expect_rd(5'h04, 32'h0000_0000, "R10 timeout cleared");
        ticks(8);
        expect_rd(5'h04, 32'h0006_0008, "R6 second-stage status");
        chk_act(1, "R6 one action pulse");
        ticks(8);
        chk_act(1, "R8 no repeat request");
        wr(5'h04, 32'hFFFF_FFFF, 4'b1111);
        expect_rd(5'h04, 32'h0000_0000, "R10 all status cleared");

        // R7 no-reboot gating, R8 restart
        wr(5'h00, 32'h0000_0000, 4'b0011);
        no_reboot = 1'b1;
        ticks(16);
        expect_rd(5'h04, 32'h0006_0008, "R7 status with no-reboot");
        chk_act(1, "R7 request suppressed");
        no_reboot = 1'b0;
        wr(5'h04, 32'hFFFF_FFFF, 4'b1111);
        wr(5'h00, 32'h0000_0000, 4'b0011);
        ticks(16);
        chk_act(2, "R8 request after reload restart");

        // R5 mask and max count
        wr(5'h08, 32'h0000_0800, 4'b0010);
        wr(5'h0C, 32'h0000_FFFF, 4'b0011);
        expect_rd(5'h0C, 32'h0003_03FF, "R5 timer value masked");
        wr(5'h00, 32'h0000_0000, 4'b0011);
        wr(5'h04, 32'hFFFF_FFFF, 4'b1111);
        wr(5'h08, 32'h0000_0000, 4'b0010);
        ticks(1022);
        expect_rd(5'h00, 32'h0000_0001, "R5 count one before max expiry");
        expect_rd(5'h04, 32'h0000_0000, "R5 no timeout yet");
        ticks(1);
        expect_rd(5'h04, 32'h0000_0008, "R5 timeout on last tick");

        // R9 mailbox
        wr(5'h08, 32'h0000_0800, 4'b0010);
        wr(5'h04, 32'hFFFF_FFFF, 4'b1111);
        wr(5'h00, 32'h00AB_0000, 4'b0100);
        expect_rd(5'h04, 32'h0000_0003, "R9 data-in raises status");
        expect_rd(5'h00, 32'h00AB_03FF, "R9 data-in stored, no reload");
        wr(5'h04, 32'h0000_0003, 4'b0001);
        wr(5'h00, 32'hCD00_0000, 4'b1000);
        expect_rd(5'h04, 32'h0000_0003, "R9 data-out raises status");
        expect_rd(5'h00, 32'hCDAB_03FF, "R9 data-out stored");

        // R11 lock
        wr(5'h08, 32'h0000_1000, 4'b0010);
        expect_rd(5'h08, 32'h0008_1000, "R11 lock set");
        wr(5'h08, 32'h0000_0000, 4'b0010);
        expect_rd(5'h08, 32'h0008_1000, "R11 lock held");
        wr(5'h08, 32'h0000_0800, 4'b0010);
        expect_rd(5'h08, 32'h0008_1800, "R11 halt still writable");

        // R12 byte enables
        wr(5'h10, 32'h0033_2211, 4'b0001);
        expect_rd(5'h10, 32'h0000_0011, "R12 byte 0 only");
        wr(5'h10, 32'h0033_2211, 4'b0110);
        expect_rd(5'h10, 32'h0033_2211, "R12 bytes 1 and 2");
        wr(5'h08, 32'h0055_0000, 4'b0100);
        expect_rd(5'h08, 32'h0055_1800, "R12 control-two low byte");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule